// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software by counting bus-clock cycles down from a preset. When the count reaches zero, the watchdog responds in one of two ways. In the direct mode it drives a system reset pulse at once. In the staged mode the first expiry raises an interrupt, and the counter starts a new period. If software has not cleared that interrupt by the next expiry, the reset pulse follows. Software keeps the system alive by writing a fixed key to a restart register before each period runs out.

Software reaches the block through a single-cycle register bus: a write strobe, a word address, write data and combinational read data. A 4-bit range index selects one of sixteen timeout periods, each a power of two. The width of the reset pulse can be set in cycles. After software enables the watchdog, the control word is locked. Only the block's own reset returns it to the idle state.

Top module: `wts_top`

## Requirements
- R1: After `rst_n` is deasserted, `irq_o` and `sys_rst_o` are low, CTRL (address 0) and COUNT (address 6) read 0, and the block stays idle until it is enabled.
- R2: A CTRL write with bit 0 set starts the watchdog and loads COUNT with 2^(RANGE_BASE+n)-1, where n is the range index. COUNT then falls by one per clock. The response to the expiry appears 2^(RANGE_BASE+n) cycles after the enabling write, and the counter reloads at each expiry.
- R3: In direct mode (CTRL bit 1 = 0), each expiry starts a reset pulse on `sys_rst_o` and never raises `irq_o`.
- R4: In staged mode (CTRL bit 1 = 1), an expiry with no interrupt pending sets `irq_o` and does not reset.
- R5: In staged mode, an expiry while the interrupt is still pending starts a reset pulse exactly one period after the interrupt, and clears the interrupt.
- R6: Writing a word with bit 0 set to the clear register (address 4) drops `irq_o` on the next cycle. A later expiry then raises the interrupt again instead of resetting.
- R7: Writing exactly 0x76 to the restart register (address 2) reloads the counter, so the next expiry falls one full period after that write. Any other value written there leaves the countdown unchanged.
- R8: `sys_rst_o` stays high for L consecutive cycles, where L is the value in the pulse register (address 5). An L of 0 gives one cycle.
- R9: Once the watchdog is enabled, writes to CTRL are ignored. It cannot be stopped, and its mode cannot change.
- R10: The range index is written at address 1, bits 3:0. A change takes effect at the next reload, and the period already running finishes at its old length.
- R11: Address 3 bit 0 reads the pending interrupt. Address 6 reads the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, also the count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | First-stage interrupt, level |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
With RANGE_BASE at 16, the shortest period is 65536 cycles, and the staged sequence would take far too long to exercise repeatedly. The bench therefore builds the block with RANGE_BASE = 2, which makes the periods 4, 8, 16, 32 and 64 cycles for range indices 0 to 4. This reaches, in a few hundred cycles, both response modes, the second-stage reset, a clear arriving between two expiries, and a range change during a running period. CNT_W, DATA_W and PULSE_W keep their defaults, so the pulse register accepts the full range of lengths, including 0.

// File: rtl/wts_pkg.sv
`timescale 1ns/1ps
package wts_pkg;
   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_RANGE = 3'd1;
   localparam logic [ADDR_W-1:0] A_KICK  = 3'd2;
   localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
   localparam logic [ADDR_W-1:0] A_CLR   = 3'd4;
   localparam logic [ADDR_W-1:0] A_PULSE = 3'd5;
   localparam logic [ADDR_W-1:0] A_COUNT = 3'd6;

   localparam int unsigned KICK_KEY = 32'h76;

   typedef enum logic {
      RESP_RESET     = 1'b0,
      RESP_IRQ_FIRST = 1'b1
   } resp_mode_e;
endpackage

// File: rtl/wts_regs.sv
`timescale 1ns/1ps
module wts_regs
   import wts_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned RSEL_W  = 4,
   parameter int unsigned PULSE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                irq_i,
   input  logic [CNT_W-1:0]    cnt_i,
   output logic                en_o,
   output resp_mode_e          mode_o,
   output logic [RSEL_W-1:0]   rsel_o,
   output logic [PULSE_W-1:0]  plen_o,
   output logic                start_o,
   output logic                kick_o,
   output logic                clr_o
);
   localparam logic [DATA_W-1:0] KEY = DATA_W'(KICK_KEY);

   logic wr_ctrl, wr_range, wr_pulse;

   assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
   assign wr_range = bus_wr && (bus_addr == A_RANGE);
   assign wr_pulse = bus_wr && (bus_addr == A_PULSE);

   // control word locks for good once the watchdog runs
   assign start_o = wr_ctrl && !en_o && bus_wdata[0];
   assign kick_o  = bus_wr && (bus_addr == A_KICK) && (bus_wdata == KEY);
   assign clr_o   = bus_wr && (bus_addr == A_CLR) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= 1'b0;
         mode_o <= RESP_RESET;
      end else if (wr_ctrl && !en_o) begin
         en_o   <= bus_wdata[0];
         mode_o <= resp_mode_e'(bus_wdata[1]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsel_o <= '0;
      end else if (wr_range) begin
         rsel_o <= bus_wdata[RSEL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         plen_o <= '0;
      end else if (wr_pulse) begin
         plen_o <= bus_wdata[PULSE_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            bus_rdata[0] = en_o;
            bus_rdata[1] = mode_o;
         end
         A_RANGE: bus_rdata[RSEL_W-1:0]  = rsel_o;
         A_STAT:  bus_rdata[0]           = irq_i;
         A_PULSE: bus_rdata[PULSE_W-1:0] = plen_o;
         A_COUNT: bus_rdata[CNT_W-1:0]   = cnt_i;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wts_counter.sv
`timescale 1ns/1ps
module wts_counter #(
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned RSEL_W     = 4,
   parameter int unsigned RANGE_BASE = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic               start_i,
   input  logic               kick_i,
   input  logic [RSEL_W-1:0]  rsel_i,
   output logic [CNT_W-1:0]   cnt_o,
   output logic [CNT_W-1:0]   preset_o,
   output logic               tmo_o
);
   localparam int unsigned NUM_R = 1 << RSEL_W;

   logic [CNT_W-1:0] preset_tab [NUM_R];

   for (genvar i = 0; i < NUM_R; i++) begin : g_preset
      assign preset_tab[i] = (CNT_W'(1) << (RANGE_BASE + i)) - CNT_W'(1);
   end

   assign preset_o = preset_tab[rsel_i];

   // a restart in the same cycle as zero wins over the expiry
   assign tmo_o = en_i && (cnt_o == '0) && !kick_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (start_i || (en_i && kick_i) || tmo_o) begin
         cnt_o <= preset_o;
      end else if (en_i) begin
         cnt_o <= cnt_o - CNT_W'(1);
      end
   end
endmodule

// File: rtl/wts_response.sv
`timescale 1ns/1ps
module wts_response
   import wts_pkg::*;
#(
   parameter int unsigned PULSE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  resp_mode_e         mode_i,
   input  logic               tmo_i,
   input  logic               clr_i,
   input  logic [PULSE_W-1:0] plen_i,
   output logic               irq_o,
   output logic               sys_rst_o
);
   logic               pend_eff;
   logic               fire;
   logic [PULSE_W-1:0] load_len;
   logic [PULSE_W-1:0] rcnt;

   // a clear landing with the expiry counts as served
   assign pend_eff = irq_o && !clr_i;
   assign fire     = tmo_i && ((mode_i == RESP_RESET) || pend_eff);
   assign load_len = (plen_i == '0) ? PULSE_W'(1) : plen_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
      end else if (fire) begin
         irq_o <= 1'b0;
      end else if (tmo_i) begin
         irq_o <= 1'b1;
      end else if (clr_i) begin
         irq_o <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt <= '0;
      end else if (fire) begin
         rcnt <= load_len;
      end else if (rcnt != '0) begin
         rcnt <= rcnt - PULSE_W'(1);
      end
   end

   assign sys_rst_o = (rcnt != '0);
endmodule

// File: rtl/wts_top.sv
`timescale 1ns/1ps
module wts_top
   import wts_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned RSEL_W     = 4,
   parameter int unsigned RANGE_BASE = 16,
   parameter int unsigned PULSE_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              sys_rst_o
);
   localparam int unsigned TOP_EXP = RANGE_BASE + (1 << RSEL_W) - 1;

   if (TOP_EXP >= CNT_W) begin : g_bad_range
      $error("wts_top: largest range needs more than CNT_W bits");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("wts_top: CNT_W must not exceed DATA_W");
   end
   if ((PULSE_W > DATA_W) || (PULSE_W < 1)) begin : g_bad_pulse
      $error("wts_top: PULSE_W out of range");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("wts_top: DATA_W must hold the restart key");
   end

   logic               en;
   resp_mode_e         mode;
   logic [RSEL_W-1:0]  rsel;
   logic [PULSE_W-1:0] plen;
   logic               start, kick, clr, tmo;
   logic [CNT_W-1:0]   cnt, preset;

   wts_regs #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .RSEL_W (RSEL_W),
      .PULSE_W(PULSE_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .irq_i    (irq_o),
      .cnt_i    (cnt),
      .en_o     (en),
      .mode_o   (mode),
      .rsel_o   (rsel),
      .plen_o   (plen),
      .start_o  (start),
      .kick_o   (kick),
      .clr_o    (clr)
   );

   wts_counter #(
      .CNT_W     (CNT_W),
      .RSEL_W    (RSEL_W),
      .RANGE_BASE(RANGE_BASE)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en),
      .start_i (start),
      .kick_i  (kick),
      .rsel_i  (rsel),
      .cnt_o   (cnt),
      .preset_o(preset),
      .tmo_o   (tmo)
   );

   wts_response #(
      .PULSE_W(PULSE_W)
   ) u_resp (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (mode),
      .tmo_i    (tmo),
      .clr_i    (clr),
      .plen_i   (plen),
      .irq_o    (irq_o),
      .sys_rst_o(sys_rst_o)
   );
endmodule

// File: rtl/wts_checker.sv
`timescale 1ns/1ps
module wts_checker #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             mode,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] preset,
   input logic             kick,
   input logic             clr,
   input logic             tmo,
   input logic             irq_o,
   input logic             sys_rst_o
);
   AST_CNT_DECR: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (cnt != '0) && !kick) |=> (cnt == $past(cnt) - CNT_W'(1))); // R2

   AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (cnt == '0) && !kick) |=> (cnt == $past(preset))); // R2

   AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && kick) |=> (cnt == $past(preset))); // R7

   AST_IRQ_STAGED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> mode); // R3

   AST_SECOND_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sys_rst_o) && mode) |-> $past(irq_o)); // R5

   AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !tmo) |=> !irq_o); // R6

   AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> en); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!sys_rst_o && !irq_o)); // R1
endmodule

bind wts_top wts_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .mode     (mode),
   .cnt      (cnt),
   .preset   (preset),
   .kick     (kick),
   .clr      (clr),
   .tmo      (tmo),
   .irq_o    (irq_o),
   .sys_rst_o(sys_rst_o)
);

// File: tb/tb_wts_top.sv
`timescale 1ns/1ps
module tb_wts_top;
   localparam int RB = 2;
   localparam int NV = 5;
   localparam int VEC_RANGE [NV] = '{0, 1, 3, 2, 4};
   localparam int VEC_MODE  [NV] = '{0, 0, 0, 1, 1};
   localparam int VEC_LEN   [NV] = '{1, 3, 0, 2, 5};
   localparam int VEC_PER   [NV] = '{4, 8, 32, 16, 64};
   localparam int VEC_WIDTH [NV] = '{1, 3, 1, 2, 5};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, sys_rst_o;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wts_top #(.RANGE_BASE(RB)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .sys_rst_o(sys_rst_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bus_wr = 1'b0;
      tick(3);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a; #1;
      d = bus_rdata;
   endtask

   // sel 0: irq, 1: reset, 2: either; returns cycles since t0, -1 on timeout
   task automatic wait_evt(input int sel, input int t0, output int dt);
      dt = -1;
      for (int i = 0; i < 1000; i++) begin
         @(posedge clk); #1;
         if ((sel == 0 && irq_o) || (sel == 1 && sys_rst_o) ||
             (sel == 2 && (irq_o || sys_rst_o))) begin
            dt = cyc - t0;
            break;
         end
      end
   endtask

   task automatic pulse_width(output int w);
      w = 1;
      for (int i = 0; i < 300; i++) begin
         @(posedge clk); #1;
         if (sys_rst_o) w++;
         else break;
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int t0, t1, dt, w;

      // table of range/mode/pulse vectors
      for (int v = 0; v < NV; v++) begin
         do_reset();
         bus_write(3'd5, 32'(VEC_LEN[v]));
         bus_write(3'd1, 32'(VEC_RANGE[v]));
         bus_write(3'd0, 32'(VEC_MODE[v] * 2 + 1));
         t0 = cyc;
         if (VEC_MODE[v] == 0) begin
            wait_evt(1, t0, dt);
            check(dt == VEC_PER[v], "R2 R3 direct period", dt, VEC_PER[v]);
            check(irq_o == 1'b0, "R3 no irq in direct mode", int'(irq_o), 0);
         end else begin
            wait_evt(2, t0, dt);
            check(dt == VEC_PER[v] && irq_o && !sys_rst_o, "R4 first expiry irq", dt, VEC_PER[v]);
            t1 = cyc;
            wait_evt(1, t1, dt);
            check(dt == VEC_PER[v], "R5 second stage reset", dt, VEC_PER[v]);
            check(irq_o == 1'b0, "R5 irq cleared at reset", int'(irq_o), 0);
         end
         pulse_width(w);
         check(w == VEC_WIDTH[v], "R8 pulse width", w, VEC_WIDTH[v]);
      end

      // R1 reset state and idle
      do_reset();
      check(!irq_o && !sys_rst_o, "R1 outputs low", int'({irq_o, sys_rst_o}), 0);
      bus_read(3'd0, rd);
      check(rd == 0, "R1 ctrl reads 0", int'(rd), 0);
      bus_read(3'd6, rd);
      check(rd == 0, "R1 count reads 0", int'(rd), 0);
      bus_write(3'd2, 32'h76);
      tick(40);
      check(!irq_o && !sys_rst_o, "R1 stays idle", int'({irq_o, sys_rst_o}), 0);

      // R2 R11 count readback
      do_reset();
      bus_write(3'd1, 32'd3);
      bus_write(3'd0, 32'd1);
      bus_read(3'd6, rd);
      check(rd == 31, "R2 R11 preset loaded", int'(rd), 31);
      tick(5);
      bus_read(3'd6, rd);
      check(rd == 26, "R2 counts down", int'(rd), 26);

      // R7 wrong key ignored
      do_reset();
      bus_write(3'd1, 32'd3);
      bus_write(3'd0, 32'd1);
      t0 = cyc;
      tick(10);
      bus_write(3'd2, 32'h77);
      wait_evt(1, t0, dt);
      check(dt == 32, "R7 wrong key no effect", dt, 32);

      // R7 right key reloads
      do_reset();
      bus_write(3'd1, 32'd3);
      bus_write(3'd0, 32'd1);
      tick(10);
      bus_write(3'd2, 32'h76);
      t1 = cyc;
      wait_evt(1, t1, dt);
      check(dt == 32, "R7 key restarts period", dt, 32);

      // R6 R11 clear cancels second stage
      do_reset();
      bus_write(3'd1, 32'd2);
      bus_write(3'd0, 32'd3);
      t0 = cyc;
      wait_evt(0, t0, dt);
      check(dt == 16, "R4 irq at period", dt, 16);
      bus_read(3'd3, rd);
      check(rd == 1, "R11 status pending", int'(rd), 1);
      bus_write(3'd4, 32'd1);
      check(irq_o == 1'b0, "R6 clear drops irq", int'(irq_o), 0);
      wait_evt(2, t0, dt);
      check(dt == 32 && irq_o && !sys_rst_o, "R6 irq again, no reset", dt, 32);

      // R9 control locked
      do_reset();
      bus_write(3'd5, 32'd2);
      bus_write(3'd1, 32'd1);
      bus_write(3'd0, 32'd1);
      t0 = cyc;
      bus_write(3'd0, 32'd0);
      bus_write(3'd0, 32'd3);
      bus_read(3'd0, rd);
      check(rd == 1, "R9 ctrl unchanged", int'(rd), 1);
      wait_evt(2, t0, dt);
      check(dt == 8 && sys_rst_o && !irq_o, "R9 still direct mode", dt, 8);

      // R10 range change waits for reload
      do_reset();
      bus_write(3'd1, 32'd1);
      bus_write(3'd0, 32'd3);
      t0 = cyc;
      bus_write(3'd1, 32'd3);
      bus_read(3'd1, rd);
      check(rd == 3, "R10 range reads back", int'(rd), 3);
      wait_evt(0, t0, dt);
      check(dt == 8, "R10 old period finishes", dt, 8);
      t1 = cyc;
      wait_evt(1, t1, dt);
      check(dt == 32, "R10 new period applied", dt, 32);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule